// File: doc/BRIEF.md
# Hardware Store Request Arbiter

This block is the control logic that sits between a battery-free nonvolatile SRAM array, its store engine, and one bidirectional open-drain pin. The pin does two jobs. When something outside pulls it low, that is a request to copy the SRAM contents into the nonvolatile cells. When the block itself pulls it low, that shows that a store is running. The pin is modelled as a synchronized input sample plus an enable for a low drive. An external pull-up is assumed.

When the synchronized pin goes low, new writes are blocked at once. Reads stay enabled for a fixed window of `DELAY_CYC` cycles. After the window, a write that is still in flight gets up to `WR_ALLOW_CYC` cycles to finish. The block then checks a dirty flag. A store is started only if at least one write has completed since the last store or recall. Otherwise the request is dropped. While any store runs, including one started by the separate direct request input, the block holds the pin low and keeps the memory disabled. After the store engine signals completion, the block releases the pin. The memory stays disabled until the pin is seen high again.

Top module: `nvs_store_arb`

## Requirements
- R1: After reset, `rd_en_o` and `wr_en_o` are 1, and `pin_pull_o` and `store_start_o` are 0.
- R2: Suppose the dirty flag is set and `pin_i` is driven low at a clock edge. Then `store_start_o` is high in the cycle after edge number `SYNC_STAGES + DELAY_CYC + 2`, counting that edge as number 1. The count assumes no write is in flight. Throughout the window, `rd_en_o` stays 1.
- R3: Suppose the dirty flag is clear when the window and drain end. Then no store starts and the pin is not pulled. `rd_en_o` returns to 1 and `wr_en_o` stays 0 until the pin is seen high again.
- R4: After the window, the drain phase holds `rd_en_o` and `wr_en_o` at 0. The drain ends when `wr_active_i` is low or after `WR_ALLOW_CYC` cycles, whichever comes first. So a write that never ends delays the start by exactly `WR_ALLOW_CYC - 1` cycles relative to R2.
- R5: From the cycle in which the synchronized pin reads low, `wr_en_o` is 0 until the synchronized pin reads high again.
- R6: `pin_pull_o` is 1 from the `store_start_o` cycle until the cycle in which `store_done_i` is seen. While it is 1, `rd_en_o` and `wr_en_o` are 0.
- R7: After `store_done_i`, `pin_pull_o` drops to 0. `rd_en_o` and `wr_en_o` stay 0 while the pin is still held low from outside. Both return to 1 within `SYNC_STAGES + 1` cycles of the pin going high.
- R8: A `wr_done_i` pulse sets the dirty flag. A store start or a `recall_start_i` pulse clears it, and the clear wins if both happen in the same cycle. A write that completes during the window still enables the store.
- R9: In the idle state, a `direct_store_i` pulse starts a store in the next cycle whether or not the dirty flag is set. The pin is pulled low as in R6.
- R10: `store_start_o` is a single-cycle pulse: it is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Raw level of the shared open-drain pin |
| pin_pull_o | output | 1 | Enables the low drive on the shared pin |
| wr_active_i | input | 1 | An SRAM write cycle is in progress |
| wr_done_i | input | 1 | Pulse: an SRAM write has completed |
| recall_start_i | input | 1 | Pulse: a recall has begun |
| direct_store_i | input | 1 | Pulse: a store request from another source |
| rd_en_o | output | 1 | SRAM reads are permitted |
| wr_en_o | output | 1 | New SRAM writes are permitted |
| store_start_o | output | 1 | One-cycle start pulse to the store engine |
| store_done_i | input | 1 | Pulse from the store engine: the store is complete |

## Verification
The bench measures the start cycle exactly, both with an idle write path and with a write that never finishes. A design that skipped the window or did not bound the drain would start early, start late, or hang. It sends a request with the dirty flag clear after a store, after a recall, and before any write has happened. A design that stored unconditionally, or cleared the flag at the wrong time, would then emit an unexpected start. It also lets a write complete inside the window, which catches a design that samples the dirty flag when the pin first falls. Finally, it holds the pin low after the store finishes. A design that re-enabled the memory on completion, or restored writes before the pin returns high, shows up in the enable outputs.

// File: rtl/nvs_arb_pkg.sv
package nvs_arb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_WINDOW = 3'd1,
      ST_DRAIN  = 3'd2,
      ST_START  = 3'd3,
      ST_BUSY   = 3'd4,
      ST_HOLD   = 3'd5,
      ST_SKIP   = 3'd6
   } arb_state_e;
endpackage

// File: rtl/nvs_pin_sync.sv
module nvs_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic sync_o
);
   if (STAGES < 1) begin : g_bad_stages
      $error("nvs_pin_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b1;
         else        q <= raw_i;
      end
      assign sync_o = q;
   end else begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '1;
         else        q <= {q[STAGES-2:0], raw_i};
      end
      assign sync_o = q[STAGES-1];
   end
endmodule

// File: rtl/nvs_cycle_timer.sv
module nvs_cycle_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart_i,
   input  logic [W-1:0] limit_i,
   output logic         expired_o
);
   logic [W-1:0] cnt_q;

   assign expired_o = (cnt_q == limit_i - W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (restart_i) cnt_q <= '0;
      else if (!expired_o) cnt_q <= cnt_q + W'(1);
   end
endmodule

// File: rtl/nvs_dirty_track.sv
module nvs_dirty_track (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clear_i,
   output logic dirty_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dirty_o <= 1'b0;
      else if (clear_i) dirty_o <= 1'b0;
      else if (set_i)   dirty_o <= 1'b1;
   end
endmodule

// File: rtl/nvs_store_arb.sv
module nvs_store_arb
   import nvs_arb_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int DELAY_CYC    = 16,
   parameter int WR_ALLOW_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic pin_pull_o,
   input  logic wr_active_i,
   input  logic wr_done_i,
   input  logic recall_start_i,
   input  logic direct_store_i,
   output logic rd_en_o,
   output logic wr_en_o,
   output logic store_start_o,
   input  logic store_done_i
);
   localparam int MAX_CYC = (DELAY_CYC > WR_ALLOW_CYC) ? DELAY_CYC : WR_ALLOW_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   if (DELAY_CYC < 1) begin : g_bad_delay
      $error("nvs_store_arb: DELAY_CYC must be at least 1");
   end
   if (WR_ALLOW_CYC < 1) begin : g_bad_allow
      $error("nvs_store_arb: WR_ALLOW_CYC must be at least 1");
   end

   arb_state_e state_q, state_n;
   logic       pin_s;
   logic       dirty;
   logic       tmr_exp;
   logic [CNT_W-1:0] tmr_limit;

   nvs_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .raw_i(pin_i), .sync_o(pin_s)
   );

   assign tmr_limit = (state_q == ST_WINDOW) ? CNT_W'(DELAY_CYC) : CNT_W'(WR_ALLOW_CYC);

   nvs_cycle_timer #(.W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n),
      .restart_i(state_n != state_q),
      .limit_i(tmr_limit),
      .expired_o(tmr_exp)
   );

   nvs_dirty_track u_dirty (
      .clk(clk), .rst_n(rst_n),
      .set_i(wr_done_i),
      .clear_i((state_q == ST_START) || recall_start_i),
      .dirty_o(dirty)
   );

   always_comb begin
      state_n = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (direct_store_i) state_n = ST_START;
            else if (!pin_s)    state_n = ST_WINDOW;
         end
         ST_WINDOW: if (tmr_exp) state_n = ST_DRAIN;
         ST_DRAIN: begin
            if (!wr_active_i || tmr_exp) state_n = dirty ? ST_START : ST_SKIP;
         end
         ST_START: state_n = ST_BUSY;
         ST_BUSY:  if (store_done_i) state_n = ST_HOLD;
         ST_HOLD:  if (pin_s) state_n = ST_IDLE;
         ST_SKIP:  if (pin_s) state_n = ST_IDLE;
         default:  state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_n;
   end

   always_comb begin
      rd_en_o       = 1'b0;
      wr_en_o       = 1'b0;
      pin_pull_o    = 1'b0;
      store_start_o = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            rd_en_o = 1'b1;
            wr_en_o = pin_s;
         end
         ST_WINDOW, ST_SKIP: rd_en_o = 1'b1;
         ST_START: begin
            pin_pull_o    = 1'b1;
            store_start_o = 1'b1;
         end
         ST_BUSY: pin_pull_o = 1'b1;
         default: ;
      endcase
   end
endmodule

// File: rtl/nvs_store_arb_chk.sv
module nvs_store_arb_chk (
   input logic clk,
   input logic rst_n,
   input logic pin_pull_o,
   input logic rd_en_o,
   input logic wr_en_o,
   input logic store_start_o,
   input logic store_done_i
);
   assert_pull_blocks_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pin_pull_o |-> (!rd_en_o && !wr_en_o));

   assert_start_pulls_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
      store_start_o |=> pin_pull_o);

   assert_pull_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_pull_o && !store_done_i) |=> pin_pull_o);

   assert_hold_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_pull_o && store_done_i && !store_start_o) |=> (!pin_pull_o && !rd_en_o && !wr_en_o));

   assert_single_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      store_start_o |=> !store_start_o);
endmodule

bind nvs_store_arb nvs_store_arb_chk u_chk (
   .clk(clk), .rst_n(rst_n), .pin_pull_o(pin_pull_o), .rd_en_o(rd_en_o),
   .wr_en_o(wr_en_o), .store_start_o(store_start_o), .store_done_i(store_done_i)
);

// File: tb/tb_nvs_store_arb.sv
module tb_nvs_store_arb;
   localparam int SYNC  = 2;
   localparam int DLY   = 6;
   localparam int ALLOW = 4;
   localparam int ENG   = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ext_low = 1'b0;
   logic wr_active = 1'b0, wr_done = 1'b0, recall = 1'b0, direct = 1'b0;
   logic store_done = 1'b0;
   logic pin, pull, rd_en, wr_en, start;

   int checks = 0, fails = 0, cyc = 0, eng_cnt = 0;
   int exp_q[$];
   bit prev_start = 1'b0;

   always #2.5 clk = ~clk;
   assign pin = !(ext_low || pull);

   nvs_store_arb #(.SYNC_STAGES(SYNC), .DELAY_CYC(DLY), .WR_ALLOW_CYC(ALLOW)) dut (
      .clk(clk), .rst_n(rst_n), .pin_i(pin), .pin_pull_o(pull),
      .wr_active_i(wr_active), .wr_done_i(wr_done), .recall_start_i(recall),
      .direct_store_i(direct), .rd_en_o(rd_en), .wr_en_o(wr_en),
      .store_start_o(start), .store_done_i(store_done)
   );

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d (cyc %0d)", req, act, exp, cyc);
      end
   endtask

   // store engine model
   always @(negedge clk) begin
      store_done <= (eng_cnt == 1);
      if (start)            eng_cnt <= ENG;
      else if (eng_cnt != 0) eng_cnt <= eng_cnt - 1;
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (start) begin
            if (exp_q.size() == 0) chk("R3/R8 unexpected store start", cyc, -1);
            else chk("R2/R4/R9 start cycle", cyc, exp_q.pop_front());
            if (prev_start) chk("R10 start pulse width", 2, 1);
         end
         prev_start = start;
      end
   end

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_write();
      wr_done = 1'b1; tick(); wr_done = 1'b0;
   endtask

   task automatic finish_store_and_release();
      tick(ENG + 3);
      chk("R7 pull released after done", int'(pull), 0);
      chk("R7 reads off while pin low", int'(rd_en), 0);
      chk("R7 writes off while pin low", int'(wr_en), 0);
      ext_low = 1'b0;
      tick(SYNC + 2);
      chk("R7 reads back on", int'(rd_en), 1);
      chk("R7 writes back on", int'(wr_en), 1);
   endtask

   initial begin
      bit wd;
      wd = 1'b0;
      fork
         begin
            tick(3); rst_n = 1'b1; tick();
            // R1
            chk("R1 rd_en", int'(rd_en), 1);
            chk("R1 wr_en", int'(wr_en), 1);
            chk("R1 pull", int'(pull), 0);
            chk("R1 start", int'(start), 0);

            // R3/R5: request with nothing written
            ext_low = 1'b1;
            tick(SYNC + 1);
            chk("R5 writes blocked on low pin", int'(wr_en), 0);
            tick(DLY + ALLOW + 6);
            chk("R3 no pull when clean", int'(pull), 0);
            chk("R3 reads restored when clean", int'(rd_en), 1);
            chk("R5 writes still blocked", int'(wr_en), 0);
            ext_low = 1'b0;
            tick(SYNC + 2);
            chk("R5 writes restored after high", int'(wr_en), 1);

            // R2/R6/R7: dirty request
            pulse_write();
            exp_q.push_back(cyc + SYNC + DLY + 2);
            ext_low = 1'b1;
            tick(SYNC + 3);
            chk("R2 reads on in window", int'(rd_en), 1);
            chk("R5 writes off in window", int'(wr_en), 0);
            tick(DLY + 1);
            chk("R6 pull during store", int'(pull), 1);
            chk("R6 pin low during store", int'(pin), 0);
            finish_store_and_release();
            chk("R2 expected start consumed", exp_q.size(), 0);

            // R8: store cleared dirty
            ext_low = 1'b1; tick(DLY + ALLOW + 8);
            chk("R8 no store after store", int'(pull), 0);
            ext_low = 1'b0; tick(SYNC + 2);

            // R8: recall clears dirty
            pulse_write();
            recall = 1'b1; tick(); recall = 1'b0;
            ext_low = 1'b1; tick(DLY + ALLOW + 8);
            chk("R8 no store after recall", int'(pull), 0);
            ext_low = 1'b0; tick(SYNC + 2);

            // R8: write completes inside the window
            exp_q.push_back(cyc + SYNC + DLY + 2);
            ext_low = 1'b1;
            tick(SYNC + 3);
            pulse_write();
            tick(DLY);
            chk("R8 late write enables store", int'(pull), 1);
            finish_store_and_release();

            // R4: write never ends, drain bounded
            pulse_write();
            wr_active = 1'b1;
            exp_q.push_back(cyc + SYNC + DLY + 1 + ALLOW);
            ext_low = 1'b1;
            tick(SYNC + DLY + 2);
            chk("R4 reads off in drain", int'(rd_en), 0);
            chk("R4 writes off in drain", int'(wr_en), 0);
            tick(ALLOW + 1);
            wr_active = 1'b0;
            finish_store_and_release();
            chk("R4 expected start consumed", exp_q.size(), 0);

            // R9: direct store with clean flag
            exp_q.push_back(cyc + 1);
            direct = 1'b1; tick(); direct = 1'b0;
            tick();
            chk("R9 pull on direct store", int'(pull), 1);
            tick(ENG + SYNC + 6);
            chk("R9 reads back on", int'(rd_en), 1);
            chk("R9 writes back on", int'(wr_en), 1);
            chk("R9 expected start consumed", exp_q.size(), 0);
         end
         begin
            tick(5000);
            wd = 1'b1;
         end
      join_any
      if (wd) chk("watchdog expired", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule